// File: doc/BRIEF.md
# Split Completion Response Evaluator

This block decides what happens to one queued transfer after the completion phase of a split transaction. The split has gone through a hub's translator to a full- or low-speed endpoint. The caller presents several inputs together with a one-cycle `rsp_valid` strobe:

- the response code returned by the translator;
- the endpoint direction;
- a flag saying the current micro-frame is too short for another attempt;
- the byte count of any data received;
- the packet size limit;
- the data-phase parity seen on the wire;
- the working state of the transfer: retry countdown, byte offset, bytes left, expected toggle, partial-split byte accumulator and four status bits.

One clock later the block returns the updated state and an action code. The action code tells the scheduler to stay in the completion phase, retry at once, leave the completion phase, go back to the start phase, or halt the queue. The block also raises flags for an illegal response, for a finished transfer and for retiring the current descriptor. The retry countdown is two bits wide. Depending on the response it is reloaded to three, counted down (stopping at zero) or kept.

Response codes used on `rsp_code`:

| Code | Response |
|------|----------|
| 0 | not yet ready |
| 1 | transaction error |
| 2 | ACK |
| 3 | MDATA |
| 4 | DATA0/1 |
| 5 | NAK |
| 6 | ERR |
| 7 | STALL |

Action codes on `action`:

| Code | Action |
|------|--------|
| 0 | stay |
| 1 | retry now |
| 2 | exit |
| 3 | restart start phase |
| 4 | halt |

Status bit positions on `status_in` and `status_out`:

| Bit | Meaning |
|-----|---------|
| 3 | active |
| 2 | halted |
| 1 | transaction-error seen |
| 0 | bus-error seen |

Top module: `csplit_resp_eval`

## Requirements
- R1: After reset every output is zero (action 0, `out_valid` low). `out_valid` is high exactly in the cycle after a cycle with `rsp_valid` high. While `rsp_valid` is low the outputs hold their last values, whatever the other inputs do.
- R2: A transaction error (code 1) with a countdown of 2 or 3 and enough time decrements the countdown, sets status bit 1, leaves offset, bytes left, toggle and accumulator unchanged, and gives action 1.
- R3: A transaction error gives action 4 when the countdown is 1 or 0, or when the endpoint is IN and time is short. The countdown is decremented (stopping at 0), status bit 1 is set, bit 3 is cleared and bit 2 is set.
- R4: A transaction error on an OUT endpoint with short time and a countdown of 2 or 3 decrements the countdown, sets status bit 1 and gives action 3.
- R5: ACK (code 2) on OUT adds min(packet limit, bytes left) to the offset and subtracts the same amount from bytes left. It inverts the toggle, sets the countdown to 3 and gives action 2.
- R6: MDATA (code 3) on IN adds the received count to the accumulator, keeps the countdown and all other state, and gives action 0.
- R7: DATA (code 4) on IN whose parity equals the toggle advances the transfer by the accumulator plus the received count, clamped to the bytes left. It clears the accumulator, inverts the toggle, keeps the countdown and gives action 2.
- R8: DATA on IN whose parity differs from the toggle clears the accumulator, changes nothing else and gives action 2.
- R9: NAK (code 5) sets the countdown to 3, leaves the transfer unchanged and gives action 2.
- R10: ERR (code 6) sets status bit 0, decrements the countdown, leaves the transfer unchanged and gives action 2.
- R11: STALL (code 7) clears status bit 3, sets bit 2, raises `retire` and gives action 4.
- R12: Not-yet-ready (code 0) changes no state and gives action 0.
- R13: ACK on IN, or MDATA/DATA on OUT, raises `illegal`, changes no state and gives action 0.
- R14: `xfer_done` is high exactly when an advance (R5 or R7) leaves zero bytes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rsp_valid | input | 1 | Response present this cycle |
| rsp_code | input | 3 | Response code |
| ep_in | input | 1 | Endpoint direction, 1 = IN |
| time_short | input | 1 | Too little micro-frame time left to retry |
| rx_bytes | input | LEN_W | Bytes received with this response |
| max_pkt | input | LEN_W | Packet size limit |
| pid_odd | input | 1 | Parity of the received data phase |
| cnt_in | input | CNT_W | Retry countdown |
| offset_in | input | OFS_W | Current byte offset |
| remain_in | input | LEN_W | Bytes left in the transfer |
| toggle_in | input | 1 | Expected data toggle |
| accum_in | input | LEN_W | Partial-split byte accumulator |
| status_in | input | 4 | Status bits |
| out_valid | output | 1 | Results updated last cycle |
| cnt_out | output | CNT_W | New countdown |
| offset_out | output | OFS_W | New offset |
| remain_out | output | LEN_W | New bytes left |
| toggle_out | output | 1 | New toggle |
| accum_out | output | LEN_W | New accumulator |
| status_out | output | 4 | New status bits |
| action | output | 3 | Next action code |
| illegal | output | 1 | Response not legal for the direction |
| xfer_done | output | 1 | Advance emptied the transfer |
| retire | output | 1 | Retire the current descriptor |

## Verification
The assertions assume that the caller keeps the state inputs coherent:

- offset plus bytes left fits the offset width;
- the accumulator and received count describe one split;
- every input is a known value in a cycle where `rsp_valid` is high.

The assertion that offset plus bytes left is conserved relies on the first point. The stimulus table uses small offsets and byte counts that stay well inside these limits. The directed tests move the inputs only while `rsp_valid` is low, to show that the outputs hold.

// File: rtl/csplit_pkg.sv
package csplit_pkg;

    localparam int LEN_W_DEF   = 11;
    localparam int OFS_W_DEF   = 15;
    localparam int CNT_MAX_DEF = 3;

    typedef enum logic [2:0] {
        RSP_NYET  = 3'd0,
        RSP_XERR  = 3'd1,
        RSP_ACK   = 3'd2,
        RSP_MDATA = 3'd3,
        RSP_DATA  = 3'd4,
        RSP_NAK   = 3'd5,
        RSP_ERR   = 3'd6,
        RSP_STALL = 3'd7
    } rsp_e;

    typedef enum logic [2:0] {
        ACT_STAY    = 3'd0,
        ACT_RETRY   = 3'd1,
        ACT_EXIT    = 3'd2,
        ACT_RESTART = 3'd3,
        ACT_HALT    = 3'd4
    } act_e;

    typedef enum logic [1:0] {
        CNT_HOLD   = 2'd0,
        CNT_RELOAD = 2'd1,
        CNT_DEC    = 2'd2
    } cnt_op_e;

    typedef struct packed {
        logic active;
        logic halted;
        logic xact_err;
        logic bus_err;
    } stat_t;

    // Direction legality of a response code
    function automatic logic rsp_legal(input rsp_e code, input logic is_in);
        case (code)
            RSP_ACK:            return !is_in;
            RSP_MDATA, RSP_DATA: return is_in;
            default:            return 1'b1;
        endcase
    endfunction

    function automatic stat_t stat_halt(input stat_t s);
        stat_t r;
        r        = s;
        r.active = 1'b0;
        r.halted = 1'b1;
        return r;
    endfunction

endpackage

// File: rtl/csplit_err_count.sv
module csplit_err_count
    import csplit_pkg::*;
#(
    parameter int CNT_MAX = CNT_MAX_DEF,
    parameter int CNT_W   = $clog2(CNT_MAX + 1)
) (
    input  logic [CNT_W-1:0] cnt_in,
    input  cnt_op_e          op,
    output logic [CNT_W-1:0] cnt_out,
    output logic             last_try
);
    localparam logic [CNT_W-1:0] RELOAD_V = CNT_W'(CNT_MAX);

    assign last_try = (cnt_in <= CNT_W'(1));

    always_comb begin
        case (op)
            CNT_RELOAD: cnt_out = RELOAD_V;
            CNT_DEC:    cnt_out = (cnt_in == '0) ? '0 : cnt_in - CNT_W'(1);
            default:    cnt_out = cnt_in;
        endcase
    end

    // R10: a decrement never raises the countdown
    always_comb begin
        if (op == CNT_DEC) begin
            a_r10_dec_not_up: assert (cnt_out <= cnt_in);
        end
    end
endmodule

// File: rtl/csplit_advance.sv
module csplit_advance #(
    parameter int LEN_W = 11,
    parameter int OFS_W = 15
) (
    input  logic             en,
    input  logic [LEN_W:0]   amount,
    input  logic [OFS_W-1:0] ofs_in,
    input  logic [LEN_W-1:0] rem_in,
    output logic [OFS_W-1:0] ofs_out,
    output logic [LEN_W-1:0] rem_out,
    output logic             done
);
    logic [LEN_W-1:0] step;

    always_comb begin
        step = (amount < {1'b0, rem_in}) ? amount[LEN_W-1:0] : rem_in;
        if (en) begin
            ofs_out = ofs_in + OFS_W'(step);
            rem_out = rem_in - step;
            done    = (rem_in == step);
        end else begin
            ofs_out = ofs_in;
            rem_out = rem_in;
            done    = 1'b0;
        end
    end
endmodule

// File: rtl/csplit_decide.sv
module csplit_decide
    import csplit_pkg::*;
#(
    parameter int LEN_W = 11
) (
    input  rsp_e             code,
    input  logic             is_in,
    input  logic             time_short,
    input  logic             last_try,
    input  logic             pid_odd,
    input  logic             tog_in,
    input  logic [LEN_W-1:0] rx_bytes,
    input  logic [LEN_W-1:0] max_pkt,
    input  logic [LEN_W-1:0] acc_in,
    input  stat_t            st_in,
    output cnt_op_e          cnt_op,
    output logic             adv_en,
    output logic [LEN_W:0]   adv_amt,
    output logic [LEN_W-1:0] acc_out,
    output logic             tog_out,
    output stat_t            st_out,
    output act_e             act,
    output logic             bad_dir,
    output logic             retire
);
    logic [LEN_W:0] total;

    assign total = {1'b0, acc_in} + {1'b0, rx_bytes};

    always_comb begin
        cnt_op  = CNT_HOLD;
        adv_en  = 1'b0;
        adv_amt = '0;
        acc_out = acc_in;
        tog_out = tog_in;
        st_out  = st_in;
        act     = ACT_STAY;
        bad_dir = 1'b0;
        retire  = 1'b0;
        if (!rsp_legal(code, is_in)) begin
            bad_dir = 1'b1;
        end else begin
            case (code)
                RSP_XERR: begin
                    cnt_op          = CNT_DEC;
                    st_out.xact_err = 1'b1;
                    if (last_try || (time_short && is_in)) begin
                        act    = ACT_HALT;
                        st_out = stat_halt(st_out);
                    end else if (time_short) begin
                        act = ACT_RESTART;
                    end else begin
                        act = ACT_RETRY;
                    end
                end
                RSP_ACK: begin
                    cnt_op  = CNT_RELOAD;
                    adv_en  = 1'b1;
                    adv_amt = {1'b0, max_pkt};
                    tog_out = !tog_in;
                    act     = ACT_EXIT;
                end
                RSP_MDATA: begin
                    acc_out = total[LEN_W-1:0];
                end
                RSP_DATA: begin
                    act     = ACT_EXIT;
                    acc_out = '0;
                    if (pid_odd == tog_in) begin
                        adv_en  = 1'b1;
                        adv_amt = total;
                        tog_out = !tog_in;
                    end
                end
                RSP_NAK: begin
                    cnt_op = CNT_RELOAD;
                    act    = ACT_EXIT;
                end
                RSP_ERR: begin
                    cnt_op         = CNT_DEC;
                    st_out.bus_err = 1'b1;
                    act            = ACT_EXIT;
                end
                RSP_STALL: begin
                    st_out = stat_halt(st_in);
                    retire = 1'b1;
                    act    = ACT_HALT;
                end
                default: ;
            endcase
        end
    end

    // R13: an illegal response never advances or retires
    always_comb begin
        if (bad_dir) begin
            a_r13_no_side_effect: assert (!adv_en && !retire && cnt_op == CNT_HOLD);
        end
    end
endmodule

// File: rtl/csplit_resp_eval.sv
module csplit_resp_eval
    import csplit_pkg::*;
#(
    parameter int LEN_W   = LEN_W_DEF,
    parameter int OFS_W   = OFS_W_DEF,
    parameter int CNT_MAX = CNT_MAX_DEF,
    parameter int CNT_W   = $clog2(CNT_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rsp_valid,
    input  logic [2:0]       rsp_code,
    input  logic             ep_in,
    input  logic             time_short,
    input  logic [LEN_W-1:0] rx_bytes,
    input  logic [LEN_W-1:0] max_pkt,
    input  logic             pid_odd,
    input  logic [CNT_W-1:0] cnt_in,
    input  logic [OFS_W-1:0] offset_in,
    input  logic [LEN_W-1:0] remain_in,
    input  logic             toggle_in,
    input  logic [LEN_W-1:0] accum_in,
    input  logic [3:0]       status_in,
    output logic             out_valid,
    output logic [CNT_W-1:0] cnt_out,
    output logic [OFS_W-1:0] offset_out,
    output logic [LEN_W-1:0] remain_out,
    output logic             toggle_out,
    output logic [LEN_W-1:0] accum_out,
    output logic [3:0]       status_out,
    output logic [2:0]       action,
    output logic             illegal,
    output logic             xfer_done,
    output logic             retire
);
    cnt_op_e          cnt_op;
    logic             last_try;
    logic [CNT_W-1:0] cnt_n;
    logic             adv_en;
    logic [LEN_W:0]   adv_amt;
    logic [OFS_W-1:0] ofs_n;
    logic [LEN_W-1:0] rem_n;
    logic             done_n;
    logic [LEN_W-1:0] acc_n;
    logic             tog_n;
    stat_t            st_n;
    act_e             act_n;
    logic             bad_n;
    logic             ret_n;

    csplit_err_count #(.CNT_MAX(CNT_MAX), .CNT_W(CNT_W)) u_cnt (
        .cnt_in  (cnt_in),
        .op      (cnt_op),
        .cnt_out (cnt_n),
        .last_try(last_try)
    );

    csplit_decide #(.LEN_W(LEN_W)) u_dec (
        .code      (rsp_e'(rsp_code)),
        .is_in     (ep_in),
        .time_short(time_short),
        .last_try  (last_try),
        .pid_odd   (pid_odd),
        .tog_in    (toggle_in),
        .rx_bytes  (rx_bytes),
        .max_pkt   (max_pkt),
        .acc_in    (accum_in),
        .st_in     (stat_t'(status_in)),
        .cnt_op    (cnt_op),
        .adv_en    (adv_en),
        .adv_amt   (adv_amt),
        .acc_out   (acc_n),
        .tog_out   (tog_n),
        .st_out    (st_n),
        .act       (act_n),
        .bad_dir   (bad_n),
        .retire    (ret_n)
    );

    csplit_advance #(.LEN_W(LEN_W), .OFS_W(OFS_W)) u_adv (
        .en     (adv_en),
        .amount (adv_amt),
        .ofs_in (offset_in),
        .rem_in (remain_in),
        .ofs_out(ofs_n),
        .rem_out(rem_n),
        .done   (done_n)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            cnt_out    <= '0;
            offset_out <= '0;
            remain_out <= '0;
            toggle_out <= 1'b0;
            accum_out  <= '0;
            status_out <= '0;
            action     <= ACT_STAY;
            illegal    <= 1'b0;
            xfer_done  <= 1'b0;
            retire     <= 1'b0;
        end else begin
            out_valid <= rsp_valid;
            if (rsp_valid) begin
                cnt_out    <= cnt_n;
                offset_out <= ofs_n;
                remain_out <= rem_n;
                toggle_out <= tog_n;
                accum_out  <= acc_n;
                status_out <= st_n;
                action     <= act_n;
                illegal    <= bad_n;
                xfer_done  <= done_n;
                retire     <= ret_n;
            end
        end
    end

    // Checks on the block's ports over time
    logic [OFS_W:0] in_sum;
    logic [OFS_W:0] out_sum;
    assign in_sum  = {1'b0, offset_in} + (OFS_W+1)'(remain_in);
    assign out_sum = {1'b0, offset_out} + (OFS_W+1)'(remain_out);

    a_r1_valid_lag: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> out_valid);

    a_r1_hold_idle: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |=> $stable(remain_out) && $stable(cnt_out) && !out_valid);

    a_r3_halt_last: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && rsp_code == RSP_XERR && cnt_in == CNT_W'(1)
        |=> action == ACT_HALT && cnt_out == '0 && status_out[2]);

    a_r7_bytes_conserved: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> out_sum == $past(in_sum));

    a_r9_nak_reload: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && rsp_code == RSP_NAK
        |=> cnt_out == CNT_W'(CNT_MAX) && action == ACT_EXIT);

    a_r11_stall_halts: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && rsp_code == RSP_STALL
        |=> action == ACT_HALT && retire && status_out[2] && !status_out[3]);

    a_r12_nyet_still: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && rsp_code == RSP_NYET
        |=> action == ACT_STAY && cnt_out == $past(cnt_in)
            && remain_out == $past(remain_in) && offset_out == $past(offset_in));

    a_r13_ack_in_bad: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && rsp_code == RSP_ACK && ep_in
        |=> illegal && cnt_out == $past(cnt_in) && remain_out == $past(remain_in));

    a_r14_done_empty: assert property (@(posedge clk) disable iff (rst)
        xfer_done |-> remain_out == '0);
endmodule

// File: tb/test_csplit_resp_eval.sv
module test_csplit_resp_eval;

    localparam int LW = 11;
    localparam int OW = 15;
    localparam int CW = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          rsp_valid = 1'b0;
    logic [2:0]    rsp_code = '0;
    logic          ep_in = 1'b0;
    logic          time_short = 1'b0;
    logic [LW-1:0] rx_bytes = '0;
    logic [LW-1:0] max_pkt = '0;
    logic          pid_odd = 1'b0;
    logic [CW-1:0] cnt_in = '0;
    logic [OW-1:0] offset_in = '0;
    logic [LW-1:0] remain_in = '0;
    logic          toggle_in = 1'b0;
    logic [LW-1:0] accum_in = '0;
    logic [3:0]    status_in = '0;

    logic          out_valid;
    logic [CW-1:0] cnt_out;
    logic [OW-1:0] offset_out;
    logic [LW-1:0] remain_out;
    logic          toggle_out;
    logic [LW-1:0] accum_out;
    logic [3:0]    status_out;
    logic [2:0]    action;
    logic          illegal;
    logic          xfer_done;
    logic          retire;

    always #4 clk = !clk;   // 125 MHz

    csplit_resp_eval i_csplit_resp_eval (
        .clk(clk), .rst(rst), .rsp_valid(rsp_valid), .rsp_code(rsp_code),
        .ep_in(ep_in), .time_short(time_short), .rx_bytes(rx_bytes),
        .max_pkt(max_pkt), .pid_odd(pid_odd), .cnt_in(cnt_in),
        .offset_in(offset_in), .remain_in(remain_in), .toggle_in(toggle_in),
        .accum_in(accum_in), .status_in(status_in), .out_valid(out_valid),
        .cnt_out(cnt_out), .offset_out(offset_out), .remain_out(remain_out),
        .toggle_out(toggle_out), .accum_out(accum_out), .status_out(status_out),
        .action(action), .illegal(illegal), .xfer_done(xfer_done), .retire(retire)
    );

    typedef struct packed {
        logic [7:0]    req;
        logic [2:0]    code;
        logic          is_in;
        logic          shrt;
        logic [LW-1:0] rx;
        logic [LW-1:0] maxp;
        logic          pid;
        logic [CW-1:0] cnt;
        logic [OW-1:0] ofs;
        logic [LW-1:0] rem;
        logic          tog;
        logic [LW-1:0] acc;
        logic [3:0]    st;
        logic [CW-1:0] e_cnt;
        logic [OW-1:0] e_ofs;
        logic [LW-1:0] e_rem;
        logic          e_tog;
        logic [LW-1:0] e_acc;
        logic [3:0]    e_st;
        logic [2:0]    e_act;
        logic          e_ill;
        logic          e_done;
        logic          e_ret;
    } vec_t;

    localparam int NV = 17;
    // fields: req code in short rx maxp pid cnt ofs rem tog acc st | cnt ofs rem tog acc st act ill done ret
    localparam vec_t VT [NV] = '{
        // R12 not yet ready
        '{8'd12, 3'd0, 1'b0, 1'b0, 11'd0, 11'd64, 1'b0, 2'd2, 15'd100, 11'd200, 1'b0, 11'd0, 4'b1000,
          2'd2, 15'd100, 11'd200, 1'b0, 11'd0, 4'b1000, 3'd0, 1'b0, 1'b0, 1'b0},
        // R2 transaction error, retry
        '{8'd2, 3'd1, 1'b1, 1'b0, 11'd5, 11'd64, 1'b0, 2'd3, 15'd0, 11'd300, 1'b1, 11'd7, 4'b1000,
          2'd2, 15'd0, 11'd300, 1'b1, 11'd7, 4'b1010, 3'd1, 1'b0, 1'b0, 1'b0},
        // R3 countdown 1 -> 0 halts
        '{8'd3, 3'd1, 1'b0, 1'b0, 11'd0, 11'd64, 1'b0, 2'd1, 15'd10, 11'd20, 1'b0, 11'd0, 4'b1000,
          2'd0, 15'd10, 11'd20, 1'b0, 11'd0, 4'b0110, 3'd4, 1'b0, 1'b0, 1'b0},
        // R3 IN with short time halts
        '{8'd3, 3'd1, 1'b1, 1'b1, 11'd0, 11'd64, 1'b0, 2'd3, 15'd10, 11'd20, 1'b0, 11'd0, 4'b1000,
          2'd2, 15'd10, 11'd20, 1'b0, 11'd0, 4'b0110, 3'd4, 1'b0, 1'b0, 1'b0},
        // R4 OUT with short time restarts
        '{8'd4, 3'd1, 1'b0, 1'b1, 11'd0, 11'd64, 1'b0, 2'd2, 15'd10, 11'd20, 1'b0, 11'd0, 4'b1000,
          2'd1, 15'd10, 11'd20, 1'b0, 11'd0, 4'b1010, 3'd3, 1'b0, 1'b0, 1'b0},
        // R5 ACK, packet limit smaller
        '{8'd5, 3'd2, 1'b0, 1'b0, 11'd0, 11'd64, 1'b0, 2'd1, 15'd100, 11'd200, 1'b0, 11'd0, 4'b1000,
          2'd3, 15'd164, 11'd136, 1'b1, 11'd0, 4'b1000, 3'd2, 1'b0, 1'b0, 1'b0},
        // R14 ACK, bytes left smaller, transfer done
        '{8'd14, 3'd2, 1'b0, 1'b0, 11'd0, 11'd64, 1'b0, 2'd2, 15'd500, 11'd30, 1'b1, 11'd0, 4'b1000,
          2'd3, 15'd530, 11'd0, 1'b0, 11'd0, 4'b1000, 3'd2, 1'b0, 1'b1, 1'b0},
        // R13 ACK on IN illegal
        '{8'd13, 3'd2, 1'b1, 1'b0, 11'd0, 11'd64, 1'b0, 2'd2, 15'd500, 11'd30, 1'b1, 11'd0, 4'b1000,
          2'd2, 15'd500, 11'd30, 1'b1, 11'd0, 4'b1000, 3'd0, 1'b1, 1'b0, 1'b0},
        // R6 MDATA accumulates
        '{8'd6, 3'd3, 1'b1, 1'b0, 11'd20, 11'd64, 1'b0, 2'd2, 15'd0, 11'd100, 1'b0, 11'd10, 4'b1000,
          2'd2, 15'd0, 11'd100, 1'b0, 11'd30, 4'b1000, 3'd0, 1'b0, 1'b0, 1'b0},
        // R7 DATA matching parity advances
        '{8'd7, 3'd4, 1'b1, 1'b0, 11'd12, 11'd64, 1'b0, 2'd1, 15'd0, 11'd100, 1'b0, 11'd30, 4'b1000,
          2'd1, 15'd42, 11'd58, 1'b1, 11'd0, 4'b1000, 3'd2, 1'b0, 1'b0, 1'b0},
        // R14 DATA empties the transfer
        '{8'd14, 3'd4, 1'b1, 1'b0, 11'd10, 11'd64, 1'b1, 2'd2, 15'd8, 11'd42, 1'b1, 11'd32, 4'b1000,
          2'd2, 15'd50, 11'd0, 1'b0, 11'd0, 4'b1000, 3'd2, 1'b0, 1'b1, 1'b0},
        // R8 DATA parity mismatch discards
        '{8'd8, 3'd4, 1'b1, 1'b0, 11'd12, 11'd64, 1'b1, 2'd2, 15'd0, 11'd100, 1'b0, 11'd30, 4'b1000,
          2'd2, 15'd0, 11'd100, 1'b0, 11'd0, 4'b1000, 3'd2, 1'b0, 1'b0, 1'b0},
        // R9 NAK reloads
        '{8'd9, 3'd5, 1'b0, 1'b0, 11'd0, 11'd64, 1'b0, 2'd1, 15'd40, 11'd60, 1'b1, 11'd0, 4'b1000,
          2'd3, 15'd40, 11'd60, 1'b1, 11'd0, 4'b1000, 3'd2, 1'b0, 1'b0, 1'b0},
        // R10 ERR decrements
        '{8'd10, 3'd6, 1'b1, 1'b0, 11'd0, 11'd64, 1'b0, 2'd2, 15'd40, 11'd60, 1'b1, 11'd0, 4'b1000,
          2'd1, 15'd40, 11'd60, 1'b1, 11'd0, 4'b1001, 3'd2, 1'b0, 1'b0, 1'b0},
        // R11 STALL halts and retires
        '{8'd11, 3'd7, 1'b1, 1'b0, 11'd0, 11'd64, 1'b0, 2'd2, 15'd40, 11'd60, 1'b1, 11'd0, 4'b1000,
          2'd2, 15'd40, 11'd60, 1'b1, 11'd0, 4'b0100, 3'd4, 1'b0, 1'b0, 1'b1},
        // R13 MDATA on OUT illegal
        '{8'd13, 3'd3, 1'b0, 1'b0, 11'd20, 11'd64, 1'b0, 2'd2, 15'd40, 11'd60, 1'b1, 11'd5, 4'b1000,
          2'd2, 15'd40, 11'd60, 1'b1, 11'd5, 4'b1000, 3'd0, 1'b1, 1'b0, 1'b0},
        // R7 DATA total clamped to bytes left
        '{8'd7, 3'd4, 1'b1, 1'b0, 11'd20, 11'd64, 1'b0, 2'd3, 15'd90, 11'd10, 1'b0, 11'd0, 4'b1000,
          2'd3, 15'd100, 11'd0, 1'b1, 11'd0, 4'b1000, 3'd2, 1'b0, 1'b1, 1'b0}
    };

    int n_vec  = 0;
    int n_fail = 0;
    bit ended  = 1'b0;

    localparam int BW = CW + OW + LW + 1 + LW + 4 + 3 + 3;

    function automatic logic [BW-1:0] got_bundle();
        return {cnt_out, offset_out, remain_out, toggle_out, accum_out, status_out,
                action, illegal, xfer_done, retire};
    endfunction

    task automatic check(input string req, input logic [BW-1:0] act_v,
                         input logic [BW-1:0] exp_v);
        n_vec++;
        if (act_v !== exp_v) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act_v, exp_v);
        end
    endtask

    task automatic apply(input vec_t v);
        @(negedge clk);
        rsp_code   = v.code;   ep_in     = v.is_in; time_short = v.shrt;
        rx_bytes   = v.rx;     max_pkt   = v.maxp;  pid_odd    = v.pid;
        cnt_in     = v.cnt;    offset_in = v.ofs;   remain_in  = v.rem;
        toggle_in  = v.tog;    accum_in  = v.acc;   status_in  = v.st;
        rsp_valid  = 1'b1;
        @(negedge clk);
        rsp_valid  = 1'b0;
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_vec++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check("R1 reset", {out_valid, got_bundle()}, '0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            apply(VT[i]);
            check($sformatf("R%0d vec%0d", VT[i].req, i), got_bundle(),
                  {VT[i].e_cnt, VT[i].e_ofs, VT[i].e_rem, VT[i].e_tog, VT[i].e_acc,
                   VT[i].e_st, VT[i].e_act, VT[i].e_ill, VT[i].e_done, VT[i].e_ret});
        end

        // R1 latency: valid one cycle after strobe, low after
        apply(VT[5]);
        check("R1 valid high", {31'd0, out_valid}, 32'd1);
        @(negedge clk);
        check("R1 valid low", {31'd0, out_valid}, 32'd0);

        // R1 idle inputs have no effect on held outputs
        remain_in = 11'd7; offset_in = 15'd3; cnt_in = 2'd0; rsp_code = 3'd7;
        repeat (3) @(negedge clk);
        check("R1 hold", got_bundle(),
              {2'd3, 15'd164, 11'd136, 1'b1, 11'd0, 4'b1000, 3'd2, 1'b0, 1'b0, 1'b0});

        // R10 ERR with zero countdown stays at zero
        apply('{8'd10, 3'd6, 1'b0, 1'b0, 11'd0, 11'd64, 1'b0, 2'd0, 15'd1, 11'd2, 1'b0, 11'd0, 4'b1000,
                2'd0, 15'd1, 11'd2, 1'b0, 11'd0, 4'b1001, 3'd2, 1'b0, 1'b0, 1'b0});
        check("R10 zero floor", {30'd0, cnt_out}, 32'd0);

        // R3 transaction error at zero countdown halts
        apply('{8'd3, 3'd1, 1'b0, 1'b0, 11'd0, 11'd64, 1'b0, 2'd0, 15'd1, 11'd2, 1'b0, 11'd0, 4'b1000,
                2'd0, 15'd1, 11'd2, 1'b0, 11'd0, 4'b0110, 3'd4, 1'b0, 1'b0, 1'b0});
        check("R3 zero halts", {29'd0, action}, 32'd4);

        // R1 reset mid-run clears outputs
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R1 reset again", {out_valid, got_bundle()}, '0);
        rst = 1'b0;

        finish_run();
    end
endmodule